// File: doc/BRIEF.md
# Two-Level PWM Blink Output Driver

This block turns a set of programmed register values into pull-low enables for sixteen open-drain port pins and one auxiliary pin. A free-running frame of 240 PWM steps is counted on an external oscillator tick. The frame is organised as 15 timeslots of 16 sub-cycles each. A 4-bit master value opens between 1 and 15 of these timeslots. Inside every open timeslot, a 4-bit per-lane level sets how many of the 16 sub-cycles are active. The level can instead come from one shared value for every lane. Each lane's polarity comes from one of two phase patterns. A blink-enable bit and a flip bit choose which pattern applies.

The auxiliary pin has two uses. It can be a seventeenth PWM lane driven by its own two phase bits, or it can carry an interrupt request straight through. All programmed values except port direction and the interrupt path are captured into a shadow bank. That capture happens only at the end of a frame, so a frame in progress is never altered. While the master value is zero, PWM is stopped, the frame counter rests at zero and the shadow bank follows its inputs one cycle late.

Top module: `pwm_blink_driver`

## Requirements
- R1: After reset every port pull-low enable is 0 and the auxiliary pull-low enable is 1, because all held values are zero.
- R2: The frame position advances only on clock edges where `pwm_tick` is 1; with the tick low and PWM running, the outputs hold. One frame spans exactly 240 ticks.
- R3: When the captured master value (`master_byte[7:4]`) is 0, every lane is static: it pulls low exactly when its selected phase bit is 0, whatever its level and the tick.
- R4: For a lane with phase bit 0, level n below 15 and master m from 1 to 15, the lane pulls low in sub-cycles 0..n of timeslots 0..m-1 and nowhere else. That gives m*(n+1) low steps per frame.
- R5: For a lane with phase bit 1, level n below 15 and master m from 1 to 15, the lane pulls low in sub-cycles n+1..15 of the open timeslots and for the whole of each closed timeslot. That gives 240-m*(n+1) low steps per frame.
- R6: Level 15 makes a lane static: low for the whole frame with phase bit 0 and never low with phase bit 1.
- R7: With `global_mode` = 0, port k takes its level from `lane_level[4k+3:4k]` and the auxiliary lane takes `master_byte[3:0]`. With `global_mode` = 1, every lane takes `master_byte[3:0]`.
- R8: With `blink_en` = 0, ports use `phase0_bits` and the auxiliary lane uses `aux_level0`, and `blink_flip` has no effect. With `blink_en` = 1, `blink_flip` = 0 selects those same sources and `blink_flip` = 1 selects `phase1_bits` and `aux_level1`.
- R9: With `irq_enable` = 1, `aux_pull_low` equals `irq_pending` in the same cycle. With `irq_enable` = 0, the auxiliary pin is the PWM lane.
- R10: A port whose `port_is_out` bit is 0 never pulls low. Direction acts without delay.
- R11: Changes to phase bits, levels, master value, blink and flip bits, global mode or auxiliary phase bits take effect only from the next frame start. While the captured master value is 0, they take effect one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_tick | input | 1 | One-cycle advance strobe from the PWM oscillator |
| port_is_out | input | 16 | 1 = port driven as output, 0 = input (released) |
| phase0_bits | input | 16 | Phase pattern 0, bit k for port k (1 = high impedance level) |
| phase1_bits | input | 16 | Phase pattern 1, bit k for port k |
| blink_en | input | 1 | Enables selection between the two phase patterns |
| blink_flip | input | 1 | Chooses pattern 1 when blinking is enabled |
| global_mode | input | 1 | Shared level for every lane |
| irq_enable | input | 1 | Auxiliary pin carries the interrupt |
| irq_pending | input | 1 | Interrupt request level (1 = pull low) |
| aux_level0 | input | 1 | Auxiliary phase bit for pattern 0 |
| aux_level1 | input | 1 | Auxiliary phase bit for pattern 1 |
| master_byte | input | 8 | [7:4] master slot count, [3:0] shared/auxiliary level |
| lane_level | input | 64 | Four bits of level per port, port k at [4k+3:4k] |
| port_pull_low | output | 16 | Pull-low enable per port |
| aux_pull_low | output | 1 | Pull-low enable for the auxiliary pin |

## Verification
The hardest state to reach from the ports is a change of programmed values partway through a running frame. Only then does the capture deferral become visible. The stimulus runs a frame for 100 ticks and pauses the tick for 20 cycles while checking that the pins hold. It then rewrites levels, phase bits and master value and finishes the frame. Per-lane low counts must still match the old settings for that frame and match the new settings for the next one. Each frame starts from a reset with the master value at zero, so the bench knows the frame position without reading internal state.

// File: rtl/pwm_blink_pkg.sv
package pwm_blink_pkg;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;
  localparam int unsigned SUBS    = 1 << LVL_W;
  localparam int unsigned SLOTS   = LVL_MAX;

  typedef logic [LVL_W-1:0] level_t;

  typedef struct packed {
    level_t slot;
    level_t sub;
  } frame_pos_t;

  // Pull-low decision of one lane at one frame position.
  function automatic logic lane_pull_low(logic phase_hi, level_t lvl,
                                         level_t master, frame_pos_t pos);
    if (master == '0 || lvl == level_t'(LVL_MAX)) return !phase_hi;
    if (pos.slot >= master) return phase_hi;
    if (!phase_hi) return (pos.sub <= lvl);
    return (pos.sub > lvl);
  endfunction

  function automatic logic lane_is_static(level_t lvl, level_t master);
    return (master == '0) || (lvl == level_t'(LVL_MAX));
  endfunction
endpackage

// File: rtl/pwm_frame_timer.sv
module pwm_frame_timer
  import pwm_blink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  output frame_pos_t pos,
  output logic       frame_wrap
);
  logic last_sub, last_slot;

  assign last_sub   = (pos.sub  == level_t'(SUBS - 1));
  assign last_slot  = (pos.slot == level_t'(SLOTS - 1));
  assign frame_wrap = run && tick && last_sub && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (!run) begin
      pos <= '0;
    end else if (tick) begin
      if (last_sub) begin
        pos.sub  <= '0;
        pos.slot <= last_slot ? '0 : pos.slot + level_t'(1);
      end else begin
        pos.sub <= pos.sub + level_t'(1);
      end
    end
  end

  p_slot_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos.slot < level_t'(SLOTS));

  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(tick)) |-> $stable(pos));

  p_restart_after_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (pos == '0));

  p_rest_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos == '0));
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  p_frozen_between_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(q));
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
  import pwm_blink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_hi,
  input  level_t     lvl,
  input  level_t     master,
  input  frame_pos_t pos,
  output logic       pull_low
);
  logic is_static;

  assign is_static = lane_is_static(lvl, master);
  assign pull_low  = lane_pull_low(phase_hi, lvl, master, pos);

  p_static_lane_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_static) && is_static && $stable(phase_hi)) |-> $stable(pull_low));
endmodule

// File: rtl/pwm_blink_driver.sv
module pwm_blink_driver
  import pwm_blink_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwm_tick,
  input  logic [NUM_PORTS-1:0]       port_is_out,
  input  logic [NUM_PORTS-1:0]       phase0_bits,
  input  logic [NUM_PORTS-1:0]       phase1_bits,
  input  logic                       blink_en,
  input  logic                       blink_flip,
  input  logic                       global_mode,
  input  logic                       irq_enable,
  input  logic                       irq_pending,
  input  logic                       aux_level0,
  input  logic                       aux_level1,
  input  logic [2*LVL_W-1:0]         master_byte,
  input  logic [NUM_PORTS*LVL_W-1:0] lane_level,
  output logic [NUM_PORTS-1:0]       port_pull_low,
  output logic                       aux_pull_low
);
  localparam int unsigned LVL_BITS = NUM_PORTS * LVL_W;
  localparam int unsigned SH_W     = 2 * NUM_PORTS + LVL_BITS + 2 * LVL_W + 5;

  logic [SH_W-1:0]      sh_d, sh_q;
  logic [NUM_PORTS-1:0] sh_ph0, sh_ph1;
  logic [LVL_BITS-1:0]  sh_levels;
  logic [2*LVL_W-1:0]   sh_master;
  logic                 sh_blink, sh_flip, sh_global, sh_aux0, sh_aux1;

  level_t               master_q, shared_lvl;
  logic                 pwm_running, frame_wrap, shadow_load, use_pattern1;
  frame_pos_t           pos;
  logic [NUM_PORTS-1:0] sel_phase, lane_low;
  logic                 aux_phase, aux_lane_low;

  assign sh_d = {phase0_bits, phase1_bits, lane_level, master_byte,
                 blink_en, blink_flip, global_mode, aux_level0, aux_level1};
  assign {sh_ph0, sh_ph1, sh_levels, sh_master,
          sh_blink, sh_flip, sh_global, sh_aux0, sh_aux1} = sh_q;

  assign master_q    = sh_master[2*LVL_W-1:LVL_W];
  assign shared_lvl  = sh_master[LVL_W-1:0];
  assign pwm_running = (master_q != '0);
  assign shadow_load = frame_wrap || !pwm_running;

  pwm_shadow_bank #(.WIDTH(SH_W)) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .load (shadow_load),
    .d    (sh_d),
    .q    (sh_q)
  );

  pwm_frame_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (pwm_tick),
    .run       (pwm_running),
    .pos       (pos),
    .frame_wrap(frame_wrap)
  );

  assign use_pattern1 = sh_blink && sh_flip;
  assign sel_phase    = use_pattern1 ? sh_ph1 : sh_ph0;
  assign aux_phase    = use_pattern1 ? sh_aux1 : sh_aux0;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    level_t port_lvl;
    assign port_lvl = sh_global ? shared_lvl : sh_levels[k*LVL_W +: LVL_W];

    pwm_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_hi(sel_phase[k]),
      .lvl     (port_lvl),
      .master  (master_q),
      .pos     (pos),
      .pull_low(lane_low[k])
    );

    assign port_pull_low[k] = port_is_out[k] && lane_low[k];
  end

  pwm_lane u_aux_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_hi(aux_phase),
    .lvl     (shared_lvl),
    .master  (master_q),
    .pos     (pos),
    .pull_low(aux_lane_low)
  );

  assign aux_pull_low = irq_enable ? irq_pending : aux_lane_low;
endmodule

// File: tb/pwm_blink_driver_test.sv
module pwm_blink_driver_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int FRAME = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_tick = 1'b0;
  logic [NP-1:0] port_is_out = '0, phase0_bits = '0, phase1_bits = '0;
  logic blink_en = 0, blink_flip = 0, global_mode = 0;
  logic irq_enable = 0, irq_pending = 0, aux_level0 = 0, aux_level1 = 0;
  logic [7:0] master_byte = '0;
  logic [NP*4-1:0] lane_level = '0;
  logic [NP-1:0] port_pull_low;
  logic aux_pull_low;

  int n_checks = 0;
  int n_fails = 0;
  logic [NP:0] hist [0:FRAME-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_blink_driver uut (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .port_is_out(port_is_out),
    .phase0_bits(phase0_bits), .phase1_bits(phase1_bits), .blink_en(blink_en),
    .blink_flip(blink_flip), .global_mode(global_mode), .irq_enable(irq_enable),
    .irq_pending(irq_pending), .aux_level0(aux_level0), .aux_level1(aux_level1),
    .master_byte(master_byte), .lane_level(lane_level),
    .port_pull_low(port_pull_low), .aux_pull_low(aux_pull_low)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Low steps expected in one frame, closed form from R3..R6.
  function automatic int exp_low(bit ph, int n, int m);
    if (m == 0 || n == 15) return ph ? 0 : FRAME;
    return ph ? FRAME - m * (n + 1) : m * (n + 1);
  endfunction

  task automatic do_reset();
    rst_n = 0; pwm_tick = 0; port_is_out = '0; phase0_bits = '0; phase1_bits = '0;
    blink_en = 0; blink_flip = 0; global_mode = 0; irq_enable = 0; irq_pending = 0;
    aux_level0 = 0; aux_level1 = 0; master_byte = '0; lane_level = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Samples n frame positions into hist[start..], advancing exactly n ticks.
  task automatic run_ticks(input int start, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwm_tick = 1;
      hist[start + i] = {aux_pull_low, port_pull_low};
    end
    @(negedge clk);
    pwm_tick = 0;
  endtask

  function automatic int tally(input int k);
    int c = 0;
    for (int i = 0; i < FRAME; i++) c += hist[i][k];
    return c;
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 ports", port_pull_low, 0);
    check("R1 aux", aux_pull_low, 1);
  endtask

  task automatic t_stopped();
    do_reset();
    port_is_out = '1; phase0_bits = 16'hA5C3; aux_level0 = 1;
    for (int k = 0; k < NP; k++) lane_level[k*4 +: 4] = 4'(k);
    @(negedge clk);
    pwm_tick = 1;
    repeat (3) @(negedge clk);
    check("R3 static ports", port_pull_low, 16'h5A3C);
    check("R3 static aux", aux_pull_low, 0);
    phase0_bits = 16'h0F0F;
    @(negedge clk);
    check("R11 stopped update", port_pull_low, 16'hF0F0);
    pwm_tick = 0;
  endtask

  task automatic t_individual();
    do_reset();
    port_is_out = 16'hFFDF; master_byte = 8'h73;
    for (int k = 0; k < NP; k++) lane_level[k*4 +: 4] = 4'(k);
    @(negedge clk);
    run_ticks(0, FRAME);
    for (int k = 0; k < NP; k++)
      check($sformatf("R4/R6/R7 port%0d count", k), tally(k), (k == 5) ? 0 : exp_low(0, k, 7));
    check("R10 input port released", tally(5), 0);
    check("R7 aux lane uses low nibble", tally(NP), exp_low(0, 3, 7));
    // port 3, level 3: low only in sub 0..3 of slots 0..6
    begin
      int bad = 0;
      for (int i = 0; i < FRAME; i++)
        if (hist[i][3] !== ((i / 16 < 7) && (i % 16 <= 3))) bad++;
      check("R4 low positions", bad, 0);
    end
  endtask

  task automatic t_phase1();
    do_reset();
    port_is_out = '1; phase0_bits = '1; master_byte = 8'h4C; aux_level0 = 1;
    for (int k = 0; k < NP; k++) lane_level[k*4 +: 4] = 4'(15 - k);
    @(negedge clk);
    run_ticks(0, FRAME);
    for (int k = 0; k < NP; k++)
      check($sformatf("R5/R6 port%0d count", k), tally(k), exp_low(1, 15 - k, 4));
    check("R5 aux count", tally(NP), exp_low(1, 12, 4));
    begin
      int bad = 0;
      for (int i = 64; i < FRAME; i++) if (hist[i][1] !== 1'b1) bad++;
      check("R5 closed slots low", bad, 0);
    end
  endtask

  task automatic t_global();
    do_reset();
    port_is_out = '1; phase0_bits = 16'h00FF; global_mode = 1; master_byte = 8'hB6;
    lane_level = '1;
    @(negedge clk);
    run_ticks(0, FRAME);
    for (int k = 0; k < NP; k++)
      check($sformatf("R7 global port%0d", k), tally(k), exp_low(phase0_bits[k], 6, 11));
    check("R7 global aux", tally(NP), exp_low(0, 6, 11));
  endtask

  task automatic t_blink();
    do_reset();
    port_is_out = '1; phase0_bits = 16'h00FF; phase1_bits = 16'hF0F0;
    aux_level0 = 0; aux_level1 = 1;
    blink_en = 0; blink_flip = 1;
    repeat (2) @(negedge clk);
    check("R8 flip ignored ports", port_pull_low, 16'hFF00);
    check("R8 flip ignored aux", aux_pull_low, 1);
    blink_en = 1; blink_flip = 0;
    repeat (2) @(negedge clk);
    check("R8 pattern0 ports", port_pull_low, 16'hFF00);
    blink_flip = 1;
    repeat (2) @(negedge clk);
    check("R8 pattern1 ports", port_pull_low, 16'h0F0F);
    check("R8 pattern1 aux", aux_pull_low, 0);
  endtask

  task automatic t_irq();
    irq_enable = 1; irq_pending = 0;
    #1 check("R9 irq idle", aux_pull_low, 0);
    irq_pending = 1;
    #1 check("R9 irq asserted", aux_pull_low, 1);
    irq_enable = 0;
    #1 check("R9 back to lane", aux_pull_low, 0);
    port_is_out = 16'h0000;
    #1 check("R10 direction immediate", port_pull_low, 0);
    irq_pending = 0;
    @(negedge clk);
  endtask

  task automatic t_defer();
    logic [NP:0] held;
    int bad = 0;
    do_reset();
    port_is_out = '1; master_byte = 8'h52;
    for (int k = 0; k < NP; k++) lane_level[k*4 +: 4] = 4'd2;
    @(negedge clk);
    run_ticks(0, 100);
    held = {aux_pull_low, port_pull_low};
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if ({aux_pull_low, port_pull_low} !== held) bad++;
    end
    check("R2 hold without tick", bad, 0);
    for (int k = 0; k < NP; k++) lane_level[k*4 +: 4] = 4'd9;
    phase0_bits = 16'h0F0F; master_byte = 8'h39;
    run_ticks(100, FRAME - 100);
    bad = 0;
    for (int k = 0; k <= NP; k++) if (tally(k) != exp_low(0, 2, 5)) bad++;
    check("R11 old frame intact", bad, 0);
    run_ticks(0, FRAME);
    for (int k = 0; k < NP; k++)
      check($sformatf("R11 new frame port%0d", k), tally(k), exp_low(phase0_bits[k], 9, 3));
    check("R11 new frame aux", tally(NP), exp_low(0, 9, 3));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_stopped();
    t_individual();
    t_phase1();
    t_global();
    t_blink();
    t_irq();
    t_defer();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule